// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit is the interrupt and DMA-request front end of a bus-mastering serial controller. It keeps six sticky event flags. The transfer engine and the data port set these flags with one-cycle pulses. The unit also holds an interrupt-enable mask and two DMA-enable bits. From these it drives a single interrupt line and two DMA request lines, one for receive and one for transmit.

Software reaches the unit through a small register port. The port has a select, a write strobe, a read strobe and registered read data. Software can read the flags, or clear some of them by writing ones. It can also read a vector register. A vector read names the lowest pending enabled source and acknowledges it in the same step. Enabling DMA for a direction drops that direction's ready interrupt from the enable mask. This keeps the processor and the DMA engine from both servicing the same event. A parameter picks the newer variant (six enable bits, self-test force) or the older one (five enable bits, no force).

Register selects: 0 status, 1 enable, 2 vector, 3 DMA configuration, 4 self-test (write only, reads 0). Flag bit 3 is receive-ready and flag bit 4 is transmit-ready.

Top module: `isv_unit`

## Requirements
- R1: `irq` is high exactly when some flag bit and the same enable bit are both 1.
- R2: `rx_dma_req` equals flag bit 3 while the receive DMA enable is 1, and is 0 otherwise. `tx_dma_req` does the same with flag bit 4 and the transmit DMA enable.
- R3: A vector read returns one plus the index of the lowest set bit of (flags AND enable), or 0 when that AND is zero. The same read clears the returned flag bit.
- R4: A vector read clears a flag only on the first cycle of a read strobe. Holding `reg_rd` high for more cycles clears nothing more.
- R5: A status write clears only the flag bits that are written as 1 and lie inside mask 0x27 (bits 0, 1, 2, 5). A status write never clears flag bits 3 and 4.
- R6: The DMA configuration register stores only bit 15 (receive enable) and bit 7 (transmit enable). Writing bit 15 as 1 clears enable bit 3. Writing bit 7 as 1 clears enable bit 4.
- R7: An enable write keeps `reg_wdata` AND 0x3F in the newer variant (`NEW_VARIANT`=1) and AND 0x1F in the older one.
- R8: A status read returns the flags in bits 5:0 and the live `bus_busy` input in bit 12. All other bits read 0.
- R9: In the newer variant, a self-test write with bit 11 set forces all six flags to 1. In the older variant the same write has no effect.
- R10: When a set pulse and a clear (by status write or by vector read) hit the same flag in the same cycle, the flag ends up set.
- R11: After reset the flags, enables and read data are 0, and all three request outputs are low.
- R12: `reg_rdata` is loaded on the first clock edge of a read strobe, with the value the selected register had before that edge. It then holds that value while the strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (level, first cycle acts) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| set_pulse | input | 6 | One-cycle set pulses, one per flag |
| bus_busy | input | 1 | Live bus-busy indication |
| irq | output | 1 | Interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle for different registers. They also assume that set pulses are not timed against a self-test force in a way the properties would have to untangle. Every property that predicts a flag clearing first excludes a same-cycle set pulse and a same-cycle force. The stimulus issues one register operation at a time and raises `set_pulse` only on purpose, in the collision cases for R10. Read strobes are always separated by at least one low cycle, except in the deliberately held read used for R4 and R12.

// File: rtl/isv_pkg.sv
package isv_pkg;
  localparam int SRC_N     = 6;
  localparam int DATA_W    = 16;
  localparam int SEL_W     = 3;
  localparam int RXRDY_BIT = 3;
  localparam int TXRDY_BIT = 4;
  localparam int BUSY_BIT  = 12;
  localparam int RXDMA_BIT = 15;
  localparam int TXDMA_BIT = 7;
  localparam int FORCE_BIT = 11;
  localparam logic [SRC_N-1:0] SW_CLR_MASK = 6'h27;

  localparam logic [SEL_W-1:0] SEL_STAT = 3'd0;
  localparam logic [SEL_W-1:0] SEL_MASK = 3'd1;
  localparam logic [SEL_W-1:0] SEL_VEC  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DMA  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_TEST = 3'd4;

  // Vector code: one plus the index of the lowest set bit, zero if none.
  function automatic logic [DATA_W-1:0] f_vector(input logic [SRC_N-1:0] pend);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (pend[i]) r = DATA_W'(i + 1);
    end
    return r;
  endfunction

  // Isolate the lowest set bit.
  function automatic logic [SRC_N-1:0] f_lowest(input logic [SRC_N-1:0] pend);
    return pend & (~pend + SRC_N'(1));
  endfunction
endpackage

// File: rtl/isv_flags.sv
module isv_flags
  import isv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_pulse,
  input  logic [SRC_N-1:0] clr_mask,
  input  logic             force_all,
  output logic [SRC_N-1:0] flags
);
  logic [SRC_N-1:0] force_vec;
  logic [SRC_N-1:0] flags_d;

  assign force_vec = force_all ? '1 : '0;
  // Set and force are applied after the clear, so they win on a collision.
  assign flags_d   = (flags & ~clr_mask) | set_pulse | force_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end
endmodule

// File: rtl/isv_prio.sv
module isv_prio
  import isv_pkg::*;
(
  input  logic [SRC_N-1:0]  pend,
  output logic [DATA_W-1:0] vec_code,
  output logic [SRC_N-1:0]  vec_onehot
);
  assign vec_code   = f_vector(pend);
  assign vec_onehot = f_lowest(pend);
endmodule

// File: rtl/isv_outgate.sv
module isv_outgate
  import isv_pkg::*;
(
  input  logic [SRC_N-1:0] flags,
  input  logic [SRC_N-1:0] en,
  input  logic             rx_dma_en,
  input  logic             tx_dma_en,
  output logic             irq,
  output logic             rx_dma_req,
  output logic             tx_dma_req
);
  assign irq        = |(flags & en);
  assign rx_dma_req = flags[RXRDY_BIT] & rx_dma_en;
  assign tx_dma_req = flags[TXRDY_BIT] & tx_dma_en;
endmodule

// File: rtl/isv_unit.sv
module isv_unit
  import isv_pkg::*;
#(
  parameter bit NEW_VARIANT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [SRC_N-1:0]  set_pulse,
  input  logic              bus_busy,
  output logic              irq,
  output logic              rx_dma_req,
  output logic              tx_dma_req
);
  localparam logic [SRC_N-1:0] EN_KEEP =
    NEW_VARIANT ? {SRC_N{1'b1}} : {1'b0, {(SRC_N-1){1'b1}}};

  logic [SRC_N-1:0]  flags;
  logic [SRC_N-1:0]  en_q;
  logic              rx_dma_en, tx_dma_en;
  logic              rd_prev_q;
  logic              rd_edge;
  logic              wr_stat, wr_mask, wr_dma, wr_test;
  logic              vec_clr_evt;
  logic              force_all;
  logic [SRC_N-1:0]  sw_clr, clr_mask, vec_onehot, dma_drop;
  logic [DATA_W-1:0] vec_code, rd_mux, stat_word, dma_word;
  logic              wdata_unused;

  assign wdata_unused = ^reg_wdata;

  // Register decode
  assign rd_edge     = reg_rd & ~rd_prev_q;
  assign wr_stat     = reg_wr && (reg_sel == SEL_STAT);
  assign wr_mask     = reg_wr && (reg_sel == SEL_MASK);
  assign wr_dma      = reg_wr && (reg_sel == SEL_DMA);
  assign wr_test     = reg_wr && (reg_sel == SEL_TEST);
  assign vec_clr_evt = rd_edge && (reg_sel == SEL_VEC);
  assign force_all   = NEW_VARIANT && wr_test && reg_wdata[FORCE_BIT];

  assign sw_clr   = wr_stat ? (reg_wdata[SRC_N-1:0] & SW_CLR_MASK) : '0;
  assign clr_mask = sw_clr | (vec_clr_evt ? vec_onehot : '0);

  always_comb begin
    dma_drop = '0;
    dma_drop[RXRDY_BIT] = reg_wdata[RXDMA_BIT];
    dma_drop[TXRDY_BIT] = reg_wdata[TXDMA_BIT];
  end

  isv_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (set_pulse),
    .clr_mask  (clr_mask),
    .force_all (force_all),
    .flags     (flags)
  );

  isv_prio u_prio (
    .pend       (flags & en_q),
    .vec_code   (vec_code),
    .vec_onehot (vec_onehot)
  );

  isv_outgate u_gate (
    .flags      (flags),
    .en         (en_q),
    .rx_dma_en  (rx_dma_en),
    .tx_dma_en  (tx_dma_en),
    .irq        (irq),
    .rx_dma_req (rx_dma_req),
    .tx_dma_req (tx_dma_req)
  );

  // Enable and DMA configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      rx_dma_en <= 1'b0;
      tx_dma_en <= 1'b0;
    end else if (wr_mask) begin
      en_q <= reg_wdata[SRC_N-1:0] & EN_KEEP;
    end else if (wr_dma) begin
      en_q      <= en_q & ~dma_drop;
      rx_dma_en <= reg_wdata[RXDMA_BIT];
      tx_dma_en <= reg_wdata[TXDMA_BIT];
    end
  end

  // Read path
  always_comb begin
    stat_word = '0;
    stat_word[SRC_N-1:0] = flags;
    stat_word[BUSY_BIT]  = bus_busy;
    dma_word = '0;
    dma_word[RXDMA_BIT]  = rx_dma_en;
    dma_word[TXDMA_BIT]  = tx_dma_en;
    case (reg_sel)
      SEL_STAT: rd_mux = stat_word;
      SEL_MASK: rd_mux = DATA_W'(en_q);
      SEL_VEC:  rd_mux = vec_code;
      SEL_DMA:  rd_mux = dma_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_prev_q <= 1'b0;
      reg_rdata <= '0;
    end else begin
      rd_prev_q <= reg_rd;
      if (rd_edge) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/isv_unit_chk.sv
module isv_unit_chk
  import isv_pkg::*;
#(
  parameter bit NEW_VARIANT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_N-1:0]  flags,
  input logic [SRC_N-1:0]  en_q,
  input logic [SRC_N-1:0]  set_pulse,
  input logic [SRC_N-1:0]  vec_onehot,
  input logic              vec_clr_evt,
  input logic              force_all,
  input logic              wr_stat,
  input logic              wr_dma,
  input logic              wd_bit0,
  input logic              wd_rxdma,
  input logic              rx_dma_en,
  input logic              tx_dma_en,
  input logic              reg_rd,
  input logic              rd_prev_q,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic              rx_dma_req,
  input logic              tx_dma_req
);
  assert_irq_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en_q) != '0) |-> irq);
  assert_irq_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en_q) == '0) |-> !irq);
  assert_dma_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_dma_en |-> !rx_dma_req) and (!tx_dma_en |-> !tx_dma_req));
  assert_vec_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_onehot));
  assert_vec_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_clr_evt && !force_all && ((set_pulse & vec_onehot) == '0))
      |=> ((flags & $past(vec_onehot)) == '0));
  assert_vec_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_clr_evt |=> !vec_clr_evt);
  assert_rdy_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !vec_clr_evt && flags[RXRDY_BIT] && flags[TXRDY_BIT])
      |=> (flags[RXRDY_BIT] && flags[TXRDY_BIT]));
  assert_sw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wd_bit0 && !set_pulse[0]) |=> !flags[0]);
  assert_dma_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dma && wd_rxdma) |=> !en_q[RXRDY_BIT]);
  assert_en_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    NEW_VARIANT || !en_q[SRC_N-1]);
  assert_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_all |=> (flags == '1));
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse != '0) |=> ((flags & $past(set_pulse)) == $past(set_pulse)));
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && rd_prev_q) |=> $stable(reg_rdata));
endmodule

bind isv_unit isv_unit_chk #(.NEW_VARIANT(NEW_VARIANT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flags       (flags),
  .en_q        (en_q),
  .set_pulse   (set_pulse),
  .vec_onehot  (vec_onehot),
  .vec_clr_evt (vec_clr_evt),
  .force_all   (force_all),
  .wr_stat     (wr_stat),
  .wr_dma      (wr_dma),
  .wd_bit0     (reg_wdata[0]),
  .wd_rxdma    (reg_wdata[15]),
  .rx_dma_en   (rx_dma_en),
  .tx_dma_en   (tx_dma_en),
  .reg_rd      (reg_rd),
  .rd_prev_q   (rd_prev_q),
  .reg_rdata   (reg_rdata),
  .irq         (irq),
  .rx_dma_req  (rx_dma_req),
  .tx_dma_req  (tx_dma_req)
);

// File: tb/isv_unit_tb.sv
module isv_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [5:0]  set_pulse = 6'h0;
  logic        bus_busy = 1'b0;
  logic [15:0] reg_rdata, old_rdata;
  logic        irq, rx_dma_req, tx_dma_req;
  logic        old_irq, old_rx, old_tx;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        mon_go = 1'b0;

  localparam logic [2:0] S_STAT = 3'd0, S_MASK = 3'd1, S_VEC = 3'd2,
                         S_DMA = 3'd3, S_TEST = 3'd4;

  always #10 clk = ~clk;

  isv_unit #(.NEW_VARIANT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .set_pulse(set_pulse), .bus_busy(bus_busy), .irq(irq),
    .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  isv_unit #(.NEW_VARIANT(1'b0)) u_old (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(old_rdata),
    .set_pulse(set_pulse), .bus_busy(bus_busy), .irq(old_irq),
    .rx_dma_req(old_rx), .tx_dma_req(old_tx)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares captured read data with queued expectations.
  always @(negedge clk) begin
    if (mon_go) begin
      mon_go = 1'b0;
      if (exp_q.size() > 0) check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic wr_reg(input logic [2:0] s, input logic [15:0] d, input logic [5:0] p = 6'h0);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1; set_pulse = p;
    @(negedge clk);
    reg_wr = 1'b0; set_pulse = 6'h0;
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk);
    set_pulse = p;
    @(negedge clk);
    set_pulse = 6'h0;
  endtask

  task automatic rd_reg(input logic [2:0] s, input logic [15:0] exp, input string tag,
                        input logic [5:0] p = 6'h0);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1; set_pulse = p;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk);
    #1 mon_go = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; set_pulse = 6'h0;
  endtask

  task automatic rd_hold(input logic [2:0] s, input logic [15:0] exp, input int n);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R12 held read data", reg_rdata, exp);
    end
    reg_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 irq", {15'h0, irq}, 16'h0);
    check("R11 dma", {14'h0, rx_dma_req, tx_dma_req}, 16'h0);
    rd_reg(S_STAT, 16'h0000, "R11 status after reset");

    // R7 enable width per variant
    wr_reg(S_MASK, 16'hFFFF);
    rd_reg(S_MASK, 16'h003F, "R7 enable new variant");
    check("R7 enable old variant", old_rdata, 16'h001F);

    // R9 self-test force
    wr_reg(S_TEST, 16'h0800);
    rd_reg(S_STAT, 16'h003F, "R9 forced flags");
    check("R9 old variant no force", old_rdata, 16'h0000);
    check("R1 irq after force", {15'h0, irq}, 16'h1);

    // R5 software clear spares ready flags
    wr_reg(S_STAT, 16'hFFFF);
    rd_reg(S_STAT, 16'h0018, "R5 write-one clear");
    rd_reg(S_VEC, 16'h0004, "R3 vector bit3");
    rd_reg(S_VEC, 16'h0005, "R3 vector bit4");
    rd_reg(S_VEC, 16'h0000, "R3 vector empty");
    check("R1 irq idle", {15'h0, irq}, 16'h0);

    // R1/R3 two sources pending
    pulse(6'b100010);
    check("R1 irq pending", {15'h0, irq}, 16'h1);
    rd_reg(S_VEC, 16'h0002, "R3 lowest first");
    rd_reg(S_VEC, 16'h0006, "R3 top source");
    rd_reg(S_VEC, 16'h0000, "R3 drained");

    // R1/R3 masking, R8 busy bit
    wr_reg(S_MASK, 16'h0001);
    pulse(6'b000100);
    check("R1 masked source", {15'h0, irq}, 16'h0);
    rd_reg(S_VEC, 16'h0000, "R3 masked vector");
    bus_busy = 1'b1;
    rd_reg(S_STAT, 16'h1004, "R8 busy and flags");
    bus_busy = 1'b0;
    wr_reg(S_STAT, 16'h0004);
    rd_reg(S_STAT, 16'h0000, "R5 clear bit2");

    // R2/R6 DMA gating and enable drop
    pulse(6'b011001);
    check("R2 dma disabled", {14'h0, rx_dma_req, tx_dma_req}, 16'h0);
    wr_reg(S_MASK, 16'h003F);
    wr_reg(S_DMA, 16'hFFFF);
    check("R2 dma both on", {14'h0, rx_dma_req, tx_dma_req}, 16'h3);
    rd_reg(S_DMA, 16'h8080, "R6 dma bits kept");
    rd_reg(S_MASK, 16'h0027, "R6 ready enables dropped");
    wr_reg(S_DMA, 16'h0080);
    check("R2 tx only", {14'h0, rx_dma_req, tx_dma_req}, 16'h1);
    wr_reg(S_DMA, 16'h0000);
    wr_reg(S_MASK, 16'h003F);
    wr_reg(S_STAT, 16'h003F);
    rd_reg(S_STAT, 16'h0018, "R5 ready flags survive");

    // R4/R12 held vector read acts once
    rd_hold(S_VEC, 16'h0004, 3);
    rd_reg(S_STAT, 16'h0010, "R4 single clear");
    rd_reg(S_VEC, 16'h0005, "R4 next vector");
    rd_reg(S_STAT, 16'h0000, "R4 all clear");

    // R10 set beats clear
    wr_reg(S_STAT, 16'h0001, 6'b000001);
    rd_reg(S_STAT, 16'h0001, "R10 set vs write clear");
    rd_reg(S_VEC, 16'h0001, "R10 vector code", 6'b000001);
    rd_reg(S_STAT, 16'h0001, "R10 set vs vector clear");
    wr_reg(S_STAT, 16'h0001);
    rd_reg(S_STAT, 16'h0000, "R5 final clear");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule